// File: doc/BRIEF.md
# Run-Time Depth-Adjustable Pipeline with Bypassable Padding Registers

This block is a linear valid/data pipeline of `NUM_STAGES` logical stages. Each stage ends in an output register, and a second "padding" register sits directly behind it. A padding register is either transparent, so that data and valid pass through it combinationally, or armed. An armed padding register behaves as a real register and adds one empty cycle to that stage's path. Software can therefore lengthen or shorten the pipeline one cycle at a time, for example to give a slow stage more timing margin.

The arm bits of all padding registers are held in one configuration word. Only a privileged write can change it. A write is never applied immediately. A privileged write sets a pending flag, which closes the input. The new word takes effect on the first clock edge at which every valid bit in the pipeline is zero, including the valid bits of armed padding registers. A global stall freezes every register, and a flush clears every valid bit.

The configuration controller has two states. In `CFG_RUN`, input is accepted. A privileged write takes the transition *request* into `CFG_DRAIN` and latches the requested word. In `CFG_DRAIN`, input is refused. A further privileged write takes the transition *rewrite*: it replaces the latched word and stays in `CFG_DRAIN`. When the pipeline is empty and no privileged write is present, the transition *commit* copies the latched word into the active mask and returns to `CFG_RUN`. Otherwise the transition *wait* holds `CFG_DRAIN`.

Top module: `depth_adj_pipe`

## Requirements
- R1: After reset, `act_mask` is 0, `cfg_pending` is 0, `out_valid` is 0 and `pipe_empty` is 1. While `stall` and `flush` are low, `in_ready` is 1.
- R2: A beat accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` unchanged, with `out_valid` high. With no stall in between, this happens `NUM_STAGES + popcount(act_mask)` edges later. Bit k of `act_mask` arms the padding register behind stage k, where bit 0 is the first stage.
- R3: While `stall` is high and `flush` is low, no register changes: `out_valid` keeps its value, `out_data` keeps its value while `out_valid` is high, and `in_ready` is 0.
- R4: `flush` clears every valid bit at the next edge, so `out_valid` becomes 0 and `pipe_empty` becomes 1. `in_ready` is 0 during a flush, and a beat offered in that cycle is dropped.
- R5: A write (`cfg_wr`) with `cfg_priv` high sets `cfg_pending` at the next edge. While `cfg_pending` is 1, `in_ready` is 0.
- R6: A write with `cfg_priv` low is ignored. It leaves `cfg_pending` and `act_mask` unchanged.
- R7: While `cfg_pending` is 1, the latched word is copied to `act_mask` and `cfg_pending` clears at the first edge where the pipeline is empty. `act_mask` never changes at an edge where any valid bit is set.
- R8: A privileged write while `cfg_pending` is 1 replaces the latched word, so the last such write wins. If this write lands on an edge where the pipeline is empty, the commit moves to the next edge.
- R9: `pipe_empty` is 1 exactly when no stage output register and no armed padding register holds a valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_data | input | DATA_W | Input beat payload |
| in_ready | output | 1 | Input accepted this cycle |
| stall | input | 1 | Freeze all pipeline registers |
| flush | input | 1 | Clear all valid bits |
| out_valid | output | 1 | Output beat present |
| out_data | output | DATA_W | Output beat payload |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Write is privileged |
| cfg_mask | input | NUM_STAGES | Requested padding arm bits |
| act_mask | output | NUM_STAGES | Active padding arm bits |
| cfg_pending | output | 1 | A reconfiguration is waiting for drain |
| pipe_empty | output | 1 | No valid beat anywhere in the pipeline |

## Verification
Two events can fall in the same cycle: a commit, which needs an empty pipeline, and a fresh privileged rewrite. The bench provokes this by issuing a privileged write into an idle pipeline and then a second one on the very next cycle. It expects `cfg_pending` to stay high and `act_mask` to stay unchanged for that edge, with the second word committed one edge later. Flush and stall arriving during a drain, and writes in the same cycle as accepted beats, come from the random phase. Their outcome is judged against a bench model of the pipeline's occupancy, latency and configuration state.

// File: rtl/depth_adj_pkg.sv
package depth_adj_pkg;
    typedef enum logic {
        CFG_RUN   = 1'b0,
        CFG_DRAIN = 1'b1
    } cfg_state_t;
endpackage

// File: rtl/pad_stage.sv
module pad_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              flush,
    input  logic              pad_on,
    input  logic              up_v,
    input  logic [DATA_W-1:0] up_d,
    output logic              dn_v,
    output logic [DATA_W-1:0] dn_d,
    output logic              busy
);
    logic              main_v;
    logic [DATA_W-1:0] main_d;
    logic              pad_v;
    logic [DATA_W-1:0] pad_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_v <= 1'b0;
            main_d <= '0;
        end else if (flush) begin
            main_v <= 1'b0;
        end else if (!stall) begin
            main_v <= up_v;
            if (up_v) main_d <= up_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_v <= 1'b0;
            pad_d <= '0;
        end else if (flush || !pad_on) begin
            pad_v <= 1'b0;
        end else if (!stall) begin
            pad_v <= main_v;
            if (main_v) pad_d <= main_d;
        end
    end

    always_comb begin
        if (pad_on) begin
            dn_v = pad_v;
            dn_d = pad_d;
        end else begin
            dn_v = main_v;
            dn_d = main_d;
        end
    end

    assign busy = main_v | pad_v;
endmodule

// File: rtl/depth_cfg_ctrl.sv
module depth_cfg_ctrl
    import depth_adj_pkg::*;
#(
    parameter int NUM_STAGES = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic                  cfg_priv,
    input  logic [NUM_STAGES-1:0] cfg_mask,
    input  logic                  pipe_empty,
    output logic [NUM_STAGES-1:0] act_mask,
    output logic                  pending
);
    cfg_state_t            state, state_nx;
    logic [NUM_STAGES-1:0] held_mask, held_nx;
    logic [NUM_STAGES-1:0] act_nx;
    logic                  priv_wr;

    assign priv_wr = cfg_wr & cfg_priv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CFG_RUN;
            held_mask <= '0;
            act_mask  <= '0;
        end else begin
            state     <= state_nx;
            held_mask <= held_nx;
            act_mask  <= act_nx;
        end
    end

    always_comb begin
        state_nx = state;
        held_nx  = held_mask;
        act_nx   = act_mask;
        pending  = 1'b0;
        unique case (state)
            CFG_RUN: begin
                if (priv_wr) begin          // request
                    state_nx = CFG_DRAIN;
                    held_nx  = cfg_mask;
                end
            end
            CFG_DRAIN: begin
                pending = 1'b1;
                if (priv_wr) begin          // rewrite
                    held_nx = cfg_mask;
                end else if (pipe_empty) begin  // commit
                    act_nx   = held_mask;
                    state_nx = CFG_RUN;
                end                         // otherwise wait
            end
            default: state_nx = CFG_RUN;
        endcase
    end

    AST_MASK_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mask != $past(act_mask)) |-> $past(pipe_empty && pending)); // R7

    AST_COMMIT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && pipe_empty && !priv_wr) |=> !pending); // R7

    AST_REWRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && priv_wr) |=> (pending && $stable(act_mask))); // R8
endmodule

// File: rtl/depth_adj_pipe.sv
module depth_adj_pipe #(
    parameter int NUM_STAGES = 13,
    parameter int DATA_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    output logic                  in_ready,
    input  logic                  stall,
    input  logic                  flush,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    input  logic                  cfg_wr,
    input  logic                  cfg_priv,
    input  logic [NUM_STAGES-1:0] cfg_mask,
    output logic [NUM_STAGES-1:0] act_mask,
    output logic                  cfg_pending,
    output logic                  pipe_empty
);
    localparam int LINKS = NUM_STAGES + 1;

    logic [LINKS-1:0]      lnk_v;
    logic [DATA_W-1:0]     lnk_d [0:LINKS-1];
    logic [NUM_STAGES-1:0] busy;

    assign in_ready = ~cfg_pending & ~stall & ~flush;
    assign lnk_v[0] = in_valid & in_ready;
    assign lnk_d[0] = in_data;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        pad_stage #(.DATA_W(DATA_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .stall  (stall),
            .flush  (flush),
            .pad_on (act_mask[k]),
            .up_v   (lnk_v[k]),
            .up_d   (lnk_d[k]),
            .dn_v   (lnk_v[k+1]),
            .dn_d   (lnk_d[k+1]),
            .busy   (busy[k])
        );
    end

    assign pipe_empty = ~|busy;
    assign out_valid  = lnk_v[NUM_STAGES];
    assign out_data   = lnk_d[NUM_STAGES];

    depth_cfg_ctrl #(.NUM_STAGES(NUM_STAGES)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_priv   (cfg_priv),
        .cfg_mask   (cfg_mask),
        .pipe_empty (pipe_empty),
        .act_mask   (act_mask),
        .pending    (cfg_pending)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pipe_empty && !out_valid)); // R4

    AST_STALL_HOLDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> (out_valid == $past(out_valid))); // R3

    AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush && out_valid) |=> $stable(out_data)); // R3

    AST_PEND_NEEDS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_pending) |-> $past(cfg_wr && cfg_priv)); // R5

    AST_UNPRIV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_priv && !cfg_pending) |=> (!cfg_pending && $stable(act_mask))); // R6
endmodule

// File: tb/depth_adj_pipe_test.sv
module depth_adj_pipe_test;
    localparam int N    = 13;
    localparam int W    = 16;
    localparam int MAXL = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, stall, flush, cfg_wr, cfg_priv;
    logic [W-1:0]  in_data;
    logic [N-1:0]  cfg_mask;
    logic          in_ready, out_valid, cfg_pending, pipe_empty;
    logic [W-1:0]  out_data;
    logic [N-1:0]  act_mask;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model
    logic          m_v [0:MAXL-1];
    logic [W-1:0]  m_d [0:MAXL-1];
    logic [N-1:0]  m_act, m_held;
    logic          m_pend;

    always #2 clk = ~clk;

    depth_adj_pipe #(.NUM_STAGES(N), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .stall(stall), .flush(flush),
        .out_valid(out_valid), .out_data(out_data), .cfg_wr(cfg_wr),
        .cfg_priv(cfg_priv), .cfg_mask(cfg_mask), .act_mask(act_mask),
        .cfg_pending(cfg_pending), .pipe_empty(pipe_empty)
    );

    function automatic int lat(input logic [N-1:0] m);
        int c = N;
        for (int i = 0; i < N; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic m_empty();
        logic e = 1'b1;
        for (int i = 0; i < MAXL; i++) if (m_v[i]) e = 1'b0;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model at posedge, check at next negedge
    task automatic step(input logic iv, input logic [W-1:0] id, input logic st,
                        input logic fl, input logic wr, input logic pr,
                        input logic [N-1:0] m);
        logic exp_rdy, acc, emp;
        int   l;
        in_valid = iv; in_data = id; stall = st; flush = fl;
        cfg_wr = wr; cfg_priv = pr; cfg_mask = m;
        exp_rdy = !m_pend && !st && !fl;
        #1;
        chk("R5/R3/R4 in_ready", 32'(in_ready), 32'(exp_rdy));
        @(posedge clk);
        acc = iv && exp_rdy;
        emp = m_empty();
        l   = lat(m_act);
        if (fl) begin
            for (int i = 0; i < MAXL; i++) m_v[i] = 1'b0;
        end else if (!st) begin
            for (int i = MAXL - 1; i > 0; i--) begin
                m_v[i] = m_v[i-1];
                m_d[i] = m_d[i-1];
            end
            m_v[0] = acc;
            m_d[0] = id;
            for (int i = l; i < MAXL; i++) m_v[i] = 1'b0;
        end
        if (m_pend) begin
            if (wr && pr) m_held = m;
            else if (emp) begin
                m_act  = m_held;
                m_pend = 1'b0;
            end
        end else if (wr && pr) begin
            m_pend = 1'b1;
            m_held = m;
        end
        @(negedge clk);
        l = lat(m_act);
        chk("R2 out_valid", 32'(out_valid), 32'(m_v[l-1]));
        if (m_v[l-1]) chk("R2 out_data", 32'(out_data), 32'(m_d[l-1]));
        chk("R7 act_mask", 32'(act_mask), 32'(m_act));
        chk("R5 cfg_pending", 32'(cfg_pending), 32'(m_pend));
        chk("R9 pipe_empty", 32'(pipe_empty), 32'(m_empty()));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, '0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seen;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MAXL; i++) begin m_v[i] = 0; m_d[i] = '0; end
        m_act = '0; m_held = '0; m_pend = 0;
        rst_n = 0; in_valid = 0; in_data = '0; stall = 0; flush = 0;
        cfg_wr = 0; cfg_priv = 0; cfg_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 act_mask", 32'(act_mask), 0);
        chk("R1 cfg_pending", 32'(cfg_pending), 0);
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 pipe_empty", 32'(pipe_empty), 1);
        chk("R1 in_ready", 32'(in_ready), 1);
        @(negedge clk);

        // R2 latency with no padding
        step(1, 16'hA5A5, 0, 0, 0, 0, '0);
        seen = 1;
        while (!out_valid && seen < 40) begin idle(1); seen++; end
        chk("R2 latency base", 32'(seen), 32'(N));
        idle(3);

        // R6 unprivileged write ignored
        step(0, '0, 0, 0, 1, 0, 13'h1FFF);
        chk("R6 pending stays 0", 32'(cfg_pending), 0);
        idle(2);
        chk("R6 mask unchanged", 32'(act_mask), 0);

        // R5/R7 privileged write with traffic in flight
        step(1, 16'h1111, 0, 0, 0, 0, '0);
        step(1, 16'h2222, 0, 0, 1, 1, 13'h0005);
        chk("R5 pending set", 32'(cfg_pending), 1);
        step(1, 16'h3333, 0, 0, 0, 0, '0);   // refused
        idle(N + 4);
        chk("R7 mask committed", 32'(act_mask), 32'h0005);

        // R2 latency with two padding registers
        step(1, 16'h5A5A, 0, 0, 0, 0, '0);
        seen = 1;
        while (!out_valid && seen < 40) begin idle(1); seen++; end
        chk("R2 latency padded", 32'(seen), 32'(N + 2));
        idle(3);

        // R8 rewrite on the commit cycle postpones commit
        step(0, '0, 0, 0, 1, 1, 13'h1000);
        step(0, '0, 0, 0, 1, 1, 13'h0003);
        chk("R8 still pending", 32'(cfg_pending), 1);
        chk("R8 mask held", 32'(act_mask), 32'h0005);
        idle(1);
        chk("R8 last write wins", 32'(act_mask), 32'h0003);

        // R4 flush during drain, R3 stall
        step(1, 16'h7777, 0, 0, 0, 0, '0);
        step(1, 16'h8888, 0, 0, 1, 1, 13'h1FFF);
        step(0, '0, 1, 0, 0, 0, '0);
        step(0, '0, 0, 1, 0, 0, '0);
        chk("R4 flushed empty", 32'(pipe_empty), 1);
        idle(2);
        chk("R7 full mask", 32'(act_mask), 32'h1FFF);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            step($urandom_range(0, 99) < 60, W'($urandom),
                 $urandom_range(0, 99) < 12, $urandom_range(0, 99) < 2,
                 $urandom_range(0, 99) < 3, 1'($urandom), N'($urandom));
        end
        idle(MAXL + 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule